// File: doc/BRIEF.md
# Stimulus-Port Trace Message Injector

This block turns two kinds of activity into one stream of timestamped trace records. Software writes into a 48 MB stimulus window. The byte address of each write selects a master slot and a channel, and each accepted write becomes a record that carries a master identifier, the channel number and the written data. In parallel, the block watches a 32-pin hardware event bus. Any pin that goes from low to high queues an event record that names the pin.

Both kinds of record leave through a single valid/ready output port, and each one is stamped with a free-running cycle counter. Writes use a simplified AXI write channel. The address and data are accepted together in one handshake, and a single response is returned per write. A write that falls outside the legal address window is refused with an error response and produces no record. The response to a legal write is withheld until its record has been placed in the output stage, so back-pressure on the output stream can never cause a software record to be lost.

Top module: `stim_trace_injector`

## Requirements
- R1: A write is legal when `aw_addr[31:26]` equals 6'h3F and `aw_addr[25:24]` is 0, 1 or 2. A legal write produces exactly one record with `msg_kind`=0, `msg_chan`=`aw_addr[23:8]` and `msg_data`=`w_data`. Bits `aw_addr[7:0]` have no effect on the record.
- R2: For a write record, `msg_master` is 7 bits: bit 6 is `aw_prot[1]` (1 = nonsecure) and bits 5:0 are `aw_addr[29:24]`.
- R3: A write with segment field 3, or with `aw_addr[31:26]` not equal to 6'h3F, produces no record and is answered with `b_resp`=2'b10. A legal write is answered with `b_resp`=2'b00. `b_resp` is held while `b_valid` waits for `b_ready`.
- R4: `aw_ready` and `w_ready` rise together, and only in a cycle where both `aw_valid` and `w_valid` are high and no earlier write is still in progress. Only one write is in progress at a time.
- R5: The response to a legal write is not raised until the write's record has been loaded into the output stage. While the output stage is full and stalled, `b_valid` stays low.
- R6: A rising edge on `hw_evt[i]` (sampled low on one clock edge and high on the next) produces one record with `msg_kind`=1, `msg_chan`=i, `msg_master`=0 and `msg_data`=0.
- R7: A pin that stays high produces no further records. Repeated rises on a pin whose record is still waiting collapse into one record.
- R8: When several event records are waiting, the lowest-numbered pin is sent first.
- R9: When a write record and event records are all waiting for a free output stage, the write record is sent first.
- R10: `msg_stamp` equals the number of rising clock edges with reset released before the edge that loads the record into the output stage. Successive records carry strictly increasing stamps.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and every record field hold their values.
- R12: In reset, `msg_valid`, `b_valid` and `aw_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted, raised together with w_ready |
| aw_addr | input | 32 | Write byte address |
| aw_prot | input | 3 | Protection attributes; bit 1 marks a nonsecure access |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | DATA_W | Write data |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response accepted |
| b_resp | output | 2 | 2'b00 okay, 2'b10 refused |
| hw_evt | input | EVT_N | Hardware event pins |
| msg_valid | output | 1 | Record valid |
| msg_ready | input | 1 | Record consumed |
| msg_kind | output | 1 | 0 = write record, 1 = event record |
| msg_master | output | 7 | Master identifier |
| msg_chan | output | 16 | Channel number or event pin index |
| msg_data | output | DATA_W | Write data (zero for events) |
| msg_stamp | output | TS_W | Timestamp |

## Verification
The assertions check several rules on every cycle. Records and responses must stay stable under back-pressure. The write handshake must be joint and may not happen while a response is still pending. Event records must have well-formed fields, and write records must carry a master field that belongs to a legal segment. Stamps must rise from one record to the next. Other behaviours span whole scenarios, so only the bench's scenarios can show them: that a refused write leaves no record, that pending events are merged, that events leave in lowest-pin order, that a write overtakes waiting events, and that the response is withheld while the output is stalled. The bench also shows that each stamp matches the exact cycle in which its record was loaded.

// File: rtl/sti_pkg.sv
package sti_pkg;
    localparam int ADDR_W = 32;
    localparam int MID_W  = 7;
    localparam int CHAN_W = 16;

    localparam logic [5:0] WINDOW_TAG = 6'h3F;
    localparam logic [1:0] SEG_BAD    = 2'b11;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    localparam logic KIND_SW  = 1'b0;
    localparam logic KIND_EVT = 1'b1;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_HOLD = 2'd1,
        WR_RESP = 2'd2
    } wr_state_e;
endpackage

// File: rtl/sti_addr_decode.sv
module sti_addr_decode
    import sti_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        prot_i,
    output logic              legal_o,
    output logic [MID_W-1:0]  master_o,
    output logic [CHAN_W-1:0] chan_o
);
    logic unused_bits;

    always_comb begin
        legal_o  = (addr_i[31:26] == WINDOW_TAG) && (addr_i[25:24] != SEG_BAD);
        master_o = {prot_i[1], addr_i[29:24]};
        chan_o   = addr_i[23:8];
    end

    assign unused_bits = ^{addr_i[7:0], prot_i[2], prot_i[0]};
endmodule

// File: rtl/sti_evt_collect.sv
module sti_evt_collect #(
    parameter  int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_i,
    input  logic          take_i,
    output logic          has_o,
    output logic [IW-1:0] idx_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } ec_t;

    ec_t          s_d, s_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr;

    always_comb begin
        has_o = |s_q.pend;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (s_q.pend[i]) idx_o = IW'(i);
        end
        clr        = take_i ? (N'(1) << idx_o) : '0;
        rise       = evt_i & ~s_q.prev;
        s_d.prev   = evt_i;
        s_d.pend   = (s_q.pend & ~clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sti_stamp_ctr.sv
module sti_stamp_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] stamp_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stamp_o = cnt_q;
endmodule

// File: rtl/stim_trace_injector.sv
module stim_trace_injector
    import sti_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EVT_N  = 32,
    parameter int TS_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                aw_valid,
    output logic                aw_ready,
    input  logic [ADDR_W-1:0]   aw_addr,
    input  logic [2:0]          aw_prot,
    input  logic                w_valid,
    output logic                w_ready,
    input  logic [DATA_W-1:0]   w_data,
    output logic                b_valid,
    input  logic                b_ready,
    output logic [1:0]          b_resp,
    input  logic [EVT_N-1:0]    hw_evt,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic                msg_kind,
    output logic [MID_W-1:0]    msg_master,
    output logic [CHAN_W-1:0]   msg_chan,
    output logic [DATA_W-1:0]   msg_data,
    output logic [TS_W-1:0]     msg_stamp
);
    localparam int EVT_IW = (EVT_N > 1) ? $clog2(EVT_N) : 1;

    typedef struct packed {
        logic              vld;
        logic              kind;
        logic [MID_W-1:0]  mid;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   stamp;
    } rec_t;

    typedef struct packed {
        wr_state_e         st;
        logic [1:0]        resp;
        logic [MID_W-1:0]  mid;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
        rec_t              out;
    } core_t;

    core_t              s_d, s_q;
    logic               dec_legal;
    logic [MID_W-1:0]   dec_mid;
    logic [CHAN_W-1:0]  dec_chan;
    logic               evt_has;
    logic               evt_take;
    logic [EVT_IW-1:0]  evt_idx;
    logic [TS_W-1:0]    now_stamp;
    logic               accept;
    logic               out_free;

    sti_addr_decode u_decode (
        .addr_i   (aw_addr),
        .prot_i   (aw_prot),
        .legal_o  (dec_legal),
        .master_o (dec_mid),
        .chan_o   (dec_chan)
    );

    sti_evt_collect #(.N(EVT_N)) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (hw_evt),
        .take_i (evt_take),
        .has_o  (evt_has),
        .idx_o  (evt_idx)
    );

    sti_stamp_ctr #(.W(TS_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .stamp_o (now_stamp)
    );

    always_comb begin
        s_d      = s_q;
        evt_take = 1'b0;
        accept   = (s_q.st == WR_IDLE) && aw_valid && w_valid;
        out_free = !s_q.out.vld || msg_ready;

        if (out_free) s_d.out.vld = 1'b0;

        case (s_q.st)
            WR_IDLE: begin
                if (accept) begin
                    if (dec_legal) begin
                        s_d.st   = WR_HOLD;
                        s_d.mid  = dec_mid;
                        s_d.chan = dec_chan;
                        s_d.data = w_data;
                    end else begin
                        s_d.st   = WR_RESP;
                        s_d.resp = RESP_SLVERR;
                    end
                end
            end
            WR_HOLD: begin
                if (out_free) begin
                    s_d.out.vld   = 1'b1;
                    s_d.out.kind  = KIND_SW;
                    s_d.out.mid   = s_q.mid;
                    s_d.out.chan  = s_q.chan;
                    s_d.out.data  = s_q.data;
                    s_d.out.stamp = now_stamp;
                    s_d.st        = WR_RESP;
                    s_d.resp      = RESP_OKAY;
                end
            end
            WR_RESP: begin
                if (b_ready) s_d.st = WR_IDLE;
            end
            default: s_d.st = WR_IDLE;
        endcase

        if (out_free && (s_q.st != WR_HOLD) && evt_has) begin
            s_d.out.vld   = 1'b1;
            s_d.out.kind  = KIND_EVT;
            s_d.out.mid   = '0;
            s_d.out.chan  = CHAN_W'(evt_idx);
            s_d.out.data  = '0;
            s_d.out.stamp = now_stamp;
            evt_take      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign aw_ready   = accept;
    assign w_ready    = accept;
    assign b_valid    = (s_q.st == WR_RESP);
    assign b_resp     = s_q.resp;
    assign msg_valid  = s_q.out.vld;
    assign msg_kind   = s_q.out.kind;
    assign msg_master = s_q.out.mid;
    assign msg_chan   = s_q.out.chan;
    assign msg_data   = s_q.out.data;
    assign msg_stamp  = s_q.out.stamp;
endmodule

// File: rtl/sti_trace_checker.sv
module sti_trace_checker #(
    parameter int DATA_W = 32,
    parameter int EVT_N  = 32,
    parameter int TS_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic              w_valid,
    input logic              w_ready,
    input logic              b_valid,
    input logic              b_ready,
    input logic [1:0]        b_resp,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              msg_kind,
    input logic [6:0]        msg_master,
    input logic [15:0]       msg_chan,
    input logic [DATA_W-1:0] msg_data,
    input logic [TS_W-1:0]   msg_stamp
);
    a_r11_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid &&
            $stable({msg_kind, msg_master, msg_chan, msg_data, msg_stamp}));

    a_r3_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid && !b_ready |=> b_valid && $stable(b_resp));

    a_r4_joint_accept: assert property (@(posedge clk) disable iff (!rst_n)
        aw_ready |-> w_ready && aw_valid && w_valid);

    a_r4_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> !aw_ready);

    a_r6_event_fields: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_kind |->
            msg_master == 7'd0 && msg_data == '0 && 32'(msg_chan) < EVT_N);

    a_r2_write_master: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_kind |->
            msg_master[5:2] == 4'hF && msg_master[1:0] != 2'b11);

    a_r10_stamp_rises: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid || (msg_stamp > $past(msg_stamp)));
endmodule

bind stim_trace_injector sti_trace_checker #(
    .DATA_W(DATA_W), .EVT_N(EVT_N), .TS_W(TS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .aw_valid   (aw_valid),
    .aw_ready   (aw_ready),
    .w_valid    (w_valid),
    .w_ready    (w_ready),
    .b_valid    (b_valid),
    .b_ready    (b_ready),
    .b_resp     (b_resp),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_kind   (msg_kind),
    .msg_master (msg_master),
    .msg_chan   (msg_chan),
    .msg_data   (msg_data),
    .msg_stamp  (msg_stamp)
);

// File: tb/stim_trace_injector_bench.sv
`timescale 1ns/1ps
module stim_trace_injector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 1'b0, w_valid = 1'b0, b_ready = 1'b0, msg_ready = 1'b0;
    logic [31:0] aw_addr = '0, w_data = '0, hw_evt = '0;
    logic [2:0]  aw_prot = '0;
    logic        aw_ready, w_ready, b_valid, msg_valid, msg_kind;
    logic [1:0]  b_resp;
    logic [6:0]  msg_master;
    logic [15:0] msg_chan;
    logic [31:0] msg_data, msg_stamp;

    typedef struct {
        logic        kind;
        logic [6:0]  mid;
        logic [15:0] chan;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0, n_fail = 0, cyc = 0;
    logic sink_ready = 1'b1;
    logic fresh = 1'b1;

    stim_trace_injector u_stim_trace_injector (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_prot(aw_prot),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .hw_evt(hw_evt),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_master(msg_master), .msg_chan(msg_chan), .msg_data(msg_data),
        .msg_stamp(msg_stamp)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            fresh = 1'b1;
            msg_ready = 1'b0;
        end else begin
            if (msg_valid && fresh) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R7 unexpected record", {32'(msg_kind), 16'd0, msg_chan}, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(msg_kind == e.kind && msg_master == e.mid && msg_chan == e.chan && msg_data == e.data,
                        e.tag, {msg_kind, msg_master, msg_chan, msg_data[7:0]},
                        {e.kind, e.mid, e.chan, e.data[7:0]});
                    chk(msg_stamp == 32'(cyc - 1), "R10 stamp", 64'(msg_stamp), 64'(cyc - 1));
                end
            end
            fresh = !msg_valid || sink_ready;
            msg_ready = sink_ready;
        end
    end

    task automatic expect_rec(input logic kind, input logic [6:0] mid, input logic [15:0] chan,
                              input logic [31:0] data, input string tag);
        exp_t e;
        e.kind = kind; e.mid = mid; e.chan = chan; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic put_write(input logic [31:0] addr, input logic [2:0] prot, input logic [31:0] data);
        aw_addr = addr; aw_prot = prot; w_data = data;
        aw_valid = 1'b1; w_valid = 1'b1;
        forever begin
            #1;
            if (aw_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        aw_valid = 1'b0; w_valid = 1'b0;
    endtask

    task automatic get_resp(input logic [1:0] exp, input string tag);
        b_ready = 1'b1;
        forever begin
            #1;
            if (b_valid) break;
            @(negedge clk);
        end
        chk(b_resp == exp, tag, 64'(b_resp), 64'(exp));
        @(negedge clk);
        b_ready = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!msg_valid, "R12 msg_valid in reset", 64'(msg_valid), 64'd0);
        chk(!b_valid, "R12 b_valid in reset", 64'(b_valid), 64'd0);
        chk(!aw_ready, "R12 aw_ready in reset", 64'(aw_ready), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: segment 0, secure, byte offset ff
        expect_rec(1'b0, 7'h3C, 16'h0000, 32'hA5A5_0001, "R1 R2 seg0 secure");
        put_write(32'hFC00_00FF, 3'b000, 32'hA5A5_0001);
        get_resp(2'b00, "R3 okay seg0");
        drain();

        // R2: segment 2, nonsecure, top channel
        expect_rec(1'b0, 7'h7E, 16'hFFFF, 32'h1234_5678, "R2 seg2 nonsecure");
        put_write(32'hFEFF_FF00, 3'b010, 32'h1234_5678);
        get_resp(2'b00, "R3 okay seg2");
        drain();

        // R1: byte offset does not change channel
        expect_rec(1'b0, 7'h3D, 16'h1234, 32'h0000_00AB, "R1 offset ab");
        put_write(32'hFD12_34AB, 3'b000, 32'h0000_00AB);
        get_resp(2'b00, "R3 okay seg1");
        expect_rec(1'b0, 7'h3D, 16'h1234, 32'h0000_0056, "R1 offset 56");
        put_write(32'hFD12_3456, 3'b101, 32'h0000_0056);
        get_resp(2'b00, "R3 okay seg1 again");
        drain();

        // R3: refused writes leave no record
        put_write(32'hFF00_0040, 3'b000, 32'hDEAD_0001);
        get_resp(2'b10, "R3 segment 3 refused");
        put_write(32'h7C00_0000, 3'b000, 32'hDEAD_0002);
        get_resp(2'b10, "R3 bad window tag refused");
        repeat (8) @(negedge clk);
        chk(!msg_valid, "R3 no record after refusal", 64'(msg_valid), 64'd0);

        // R4: no accept without both valids
        aw_valid = 1'b1; w_valid = 1'b0;
        #1;
        chk(!aw_ready && !w_ready, "R4 address alone", 64'({aw_ready, w_ready}), 64'd0);
        @(negedge clk);
        aw_valid = 1'b0;

        // R6: single event
        expect_rec(1'b1, 7'h00, 16'd5, 32'd0, "R6 event pin 5");
        hw_evt[5] = 1'b1;
        drain();
        hw_evt = '0;
        @(negedge clk);

        // R5/R8/R9: stalled output
        sink_ready = 1'b0;
        expect_rec(1'b1, 7'h00, 16'd7, 32'd0, "R6 event pin 7 occupant");
        hw_evt[7] = 1'b1;
        repeat (3) @(negedge clk);
        expect_rec(1'b0, 7'h3D, 16'h0056, 32'hCAFE_0009, "R9 write before events");
        put_write(32'hFD00_5600, 3'b000, 32'hCAFE_0009);
        expect_rec(1'b1, 7'h00, 16'd3, 32'd0, "R8 pin 3 first");
        expect_rec(1'b1, 7'h00, 16'd20, 32'd0, "R8 pin 20 second");
        hw_evt[20] = 1'b1; hw_evt[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk(!b_valid, "R5 response withheld", 64'(b_valid), 64'd0);
        aw_addr = 32'hFC00_0100; aw_valid = 1'b1; w_valid = 1'b1;
        #1;
        chk(!aw_ready, "R4 second write blocked", 64'(aw_ready), 64'd0);
        @(negedge clk);
        aw_valid = 1'b0; w_valid = 1'b0;
        sink_ready = 1'b1;
        get_resp(2'b00, "R5 response after release");
        drain();
        hw_evt = '0;
        @(negedge clk);

        // R7: merge repeated rises, no repeat on held level
        sink_ready = 1'b0;
        expect_rec(1'b1, 7'h00, 16'd1, 32'd0, "R7 occupant pin 1");
        hw_evt[1] = 1'b1;
        repeat (3) @(negedge clk);
        expect_rec(1'b1, 7'h00, 16'd9, 32'd0, "R7 merged pin 9");
        hw_evt[9] = 1'b1; @(negedge clk);
        hw_evt[9] = 1'b0; @(negedge clk);
        hw_evt[9] = 1'b1; @(negedge clk);
        sink_ready = 1'b1;
        drain();
        repeat (10) @(negedge clk);
        chk(!msg_valid && exp_q.size() == 0, "R7 no extra records", 64'(msg_valid), 64'd0);
        hw_evt = '0;
        @(negedge clk);

        // R8: simultaneous rises
        expect_rec(1'b1, 7'h00, 16'd0, 32'd0, "R8 pin 0");
        expect_rec(1'b1, 7'h00, 16'd4, 32'd0, "R8 pin 4");
        expect_rec(1'b1, 7'h00, 16'd31, 32'd0, "R8 pin 31");
        hw_evt = 32'h8000_0011;
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule